// File: doc/BRIEF.md
# Two-Wire Bus Condition Front End

This block sits between the raw clock and data pins of a two-wire (I2C) slave and the byte-level controller behind it. The block samples both lines with the system clock, passes each one through a two-stage synchronizer and a persistence filter, and turns the cleaned levels into single-cycle event pulses. The events are START, repeated START, STOP, and the rising and falling edges of the clock line. A busy flag runs from a START to the next STOP. After each STOP the block times out a bus-free window, and a START that falls inside that window is dropped.

The block also gates the slave's own data-line drive. The controller asks for the line to be pulled low or released. The block passes that request to the pad only while the filtered clock is low, and only after a fixed hold interval has elapsed since the last clock fall. A change made by the slave therefore can never look like a START or STOP to other devices. Clock period, spike width, hold time and both bus-free times are parameters, and the cycle counts are derived from them.

Top module: `i2c_line_monitor`

## Requirements
- R1: While reset is high and just after it is released with both lines high, bus_busy is 0, scl_level and sda_level are 1, sda_drive_low is 0 and no event pulse fires.
- R2: A raw line level must persist for FILT_CYC consecutive synchronized samples before the filtered level takes it. FILT_CYC is 4 at the default 20 ns clock, so pulses of 50 ns or less are always rejected. A low pulse on either line lasting 3 clocks changes neither level and causes no event.
- R3: When SDA falls while SCL is high, the bus is not busy and the bus-free window has expired, start_pulse is high for exactly one clock and bus_busy becomes 1.
- R4: When SDA falls while SCL is high and bus_busy is already 1, rstart_pulse fires for one clock instead of start_pulse, and bus_busy stays 1.
- R5: When SDA rises while SCL is high, stop_pulse fires for one clock and bus_busy becomes 0.
- R6: Each filtered SCL rise gives one scl_rise_pulse and each filtered SCL fall gives one scl_fall_pulse. SDA changes while SCL is low produce no event.
- R7: At most one event output is high in any cycle. If SCL rises in the same cycle that SDA changes, the START/STOP decision is reported and the rise pulse is suppressed.
- R8: After a STOP, a START is ignored (no pulse, bus_busy stays 0) until the bus-free count has elapsed: 65 clocks with fast_mode=1 and 235 clocks with fast_mode=0 at the defaults. The mode is taken at the STOP, and every STOP restarts the count.
- R9: sda_drive_low changes only while the filtered SCL is low, and no sooner than HOLD_CYC (15 at the default, i.e. 300 ns) clocks after the scl_fall_pulse of that low phase.
- R10: Once the hold interval of the current SCL low phase has elapsed, sda_drive_low follows drive_low_req within 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_raw | input | 1 | Unsynchronized clock line from the pad |
| sda_raw | input | 1 | Unsynchronized data line from the pad |
| fast_mode | input | 1 | 1 selects the short bus-free time, 0 the long one |
| drive_low_req | input | 1 | Slave request to pull SDA low |
| scl_level | output | 1 | Filtered clock line level |
| sda_level | output | 1 | Filtered data line level, for sampling on scl_rise_pulse |
| start_pulse | output | 1 | One-cycle START from an idle bus |
| rstart_pulse | output | 1 | One-cycle START while the bus is busy |
| stop_pulse | output | 1 | One-cycle STOP |
| scl_rise_pulse | output | 1 | One-cycle filtered SCL rising edge |
| scl_fall_pulse | output | 1 | One-cycle filtered SCL falling edge |
| bus_busy | output | 1 | High from an accepted START to the next STOP |
| sda_drive_low | output | 1 | Hold-gated SDA pull-down to the pad |

## Verification
The main classification is driven through a full transfer of data bits. In that transfer SDA toggles only while SCL is low, which separates data movement from bus conditions. A START issued mid-transfer tells a repeated START apart from a fresh one. A START issued right after a STOP tells an accepted START apart from one dropped by the bus-free window. A simultaneous SCL rise and SDA rise shows whether the condition takes priority over the edge pulse. Directed runs then try 3-clock and 4-clock pulses to locate the filter threshold, compare the two bus-free lengths, and measure the distance from a clock fall to the drive change.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    // One-cycle bus events produced by the classifier
    typedef struct packed {
        logic stop;
        logic start;
        logic rstart;
        logic rise;
        logic fall;
    } bus_ev_t;

    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned LINE_SCL  = 0;
    localparam int unsigned LINE_SDA  = 1;

    // Round a time in ns up to whole clock cycles
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    // Counter width able to hold the value maxval
    function automatic int unsigned cnt_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/i2cmon_glitch_filter.sv
module i2cmon_glitch_filter #(
    parameter int unsigned FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int unsigned CW = i2cmon_pkg::cnt_width(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [1:0]    sync_q;
    logic          s;
    logic [CW-1:0] run_q;
    logic          level_q;

    assign s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            run_q   <= '0;
            level_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (s == level_q) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                level_q <= s;
                run_q   <= '0;
            end else begin
                run_q <= run_q + CW'(1);
            end
        end
    end

    assign level = level_q;

    AST_FILT_PERSIST: assert property (@(posedge clk) disable iff (rst) (level_q != $past(level_q)) |-> ($past(s) == level_q && $past(s, 2) == level_q)) else $error("filtered level moved without a persistent input"); // R2

endmodule

// File: rtl/i2cmon_classifier.sv
module i2cmon_classifier import i2cmon_pkg::*; #(
    parameter int unsigned FREE_STD_CYC  = 235,
    parameter int unsigned FREE_FAST_CYC = 65
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fast_mode,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev,
    output logic    busy
);
    localparam int unsigned FREE_MAX = (FREE_STD_CYC > FREE_FAST_CYC) ? FREE_STD_CYC : FREE_FAST_CYC;
    localparam int unsigned TW = cnt_width(FREE_MAX);
    localparam logic [TW-1:0] STD_LD  = TW'(FREE_STD_CYC);
    localparam logic [TW-1:0] FAST_LD = TW'(FREE_FAST_CYC);

    logic          scl_p, sda_p;
    logic          busy_q, busy_n;
    logic [TW-1:0] free_q, free_n;
    bus_ev_t       ev_q, ev_n;
    logic          cond_start, cond_stop;

    assign cond_start = scl_f & sda_p & ~sda_f;
    assign cond_stop  = scl_f & ~sda_p & sda_f;

    always_comb begin
        ev_n   = '0;
        busy_n = busy_q;
        free_n = free_q;
        if (free_q != '0) begin
            free_n = free_q - TW'(1);
        end
        if (cond_stop) begin
            ev_n.stop = 1'b1;
            busy_n    = 1'b0;
            free_n    = fast_mode ? FAST_LD : STD_LD;
        end else if (cond_start) begin
            if (busy_q) begin
                ev_n.rstart = 1'b1;
            end else if (free_q == '0) begin
                ev_n.start = 1'b1;
                busy_n     = 1'b1;
            end
        end else begin
            ev_n.rise = scl_f & ~scl_p;
            ev_n.fall = ~scl_f & scl_p;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
            busy_q <= 1'b0;
            free_q <= '0;
            ev_q   <= '0;
        end else begin
            scl_p  <= scl_f;
            sda_p  <= sda_f;
            busy_q <= busy_n;
            free_q <= free_n;
            ev_q   <= ev_n;
        end
    end

    assign ev   = ev_q;
    assign busy = busy_q;

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst) $onehot0(ev_q)) else $error("more than one event in a cycle"); // R7
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst) ev_q.start |-> (busy_q && !$past(busy_q))) else $error("start not from idle"); // R3
    AST_BUSY_ONLY_BY_START: assert property (@(posedge clk) disable iff (rst) $rose(busy_q) |-> ev_q.start) else $error("busy without start"); // R3
    AST_RSTART_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst) ev_q.rstart |-> (busy_q && $past(busy_q))) else $error("repeated start on idle bus"); // R4
    AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst) ev_q.stop |-> !busy_q) else $error("stop left bus busy"); // R5
    AST_RISE_FOLLOWS_SCL: assert property (@(posedge clk) disable iff (rst) ev_q.rise |-> (scl_p && !$past(scl_p))) else $error("rise pulse without scl rise"); // R6

endmodule

// File: rtl/i2cmon_drive_hold.sv
module i2cmon_drive_hold #(
    parameter int unsigned HOLD_CYC = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_f,
    input  logic req,
    output logic drive
);
    localparam int unsigned HW = i2cmon_pkg::cnt_width(HOLD_CYC);
    localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYC);

    logic          scl_p;
    logic [HW-1:0] wait_q;
    logic          drive_q;
    logic          scl_fell, open_win;

    assign scl_fell = scl_p & ~scl_f;
    assign open_win = ~scl_f & ~scl_p & (wait_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p   <= 1'b1;
            wait_q  <= '0;
            drive_q <= 1'b0;
        end else begin
            scl_p <= scl_f;
            if (scl_fell) begin
                wait_q <= HOLD_LD;
            end else if (wait_q != '0) begin
                wait_q <= wait_q - HW'(1);
            end
            if (open_win) begin
                drive_q <= req;
            end
        end
    end

    assign drive = drive_q;

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) (drive_q != $past(drive_q)) |-> (!$past(scl_f) && !$past(scl_p))) else $error("drive moved outside clock-low phase"); // R9

endmodule

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor import i2cmon_pkg::*; #(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned SPIKE_NS      = 50,
    parameter int unsigned HOLD_NS       = 300,
    parameter int unsigned FREE_STD_NS   = 4700,
    parameter int unsigned FREE_FAST_NS  = 1300
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    input  logic fast_mode,
    input  logic drive_low_req,
    output logic scl_level,
    output logic sda_level,
    output logic start_pulse,
    output logic rstart_pulse,
    output logic stop_pulse,
    output logic scl_rise_pulse,
    output logic scl_fall_pulse,
    output logic bus_busy,
    output logic sda_drive_low
);
    // A spike of SPIKE_NS can cover ceil(SPIKE_NS/period) samples; one more is required
    localparam int unsigned FILT_CYC      = ns_to_cycles(SPIKE_NS, CLK_PERIOD_PS) + 1;
    localparam int unsigned HOLD_CYC      = ns_to_cycles(HOLD_NS, CLK_PERIOD_PS);
    localparam int unsigned FREE_STD_CYC  = ns_to_cycles(FREE_STD_NS, CLK_PERIOD_PS);
    localparam int unsigned FREE_FAST_CYC = ns_to_cycles(FREE_FAST_NS, CLK_PERIOD_PS);

    logic [NUM_LINES-1:0] raw_v;
    logic [NUM_LINES-1:0] lvl_v;
    bus_ev_t              ev_w;

    assign raw_v[LINE_SCL] = scl_raw;
    assign raw_v[LINE_SDA] = sda_raw;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        i2cmon_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_v[i]),
            .level (lvl_v[i])
        );
    end

    i2cmon_classifier #(
        .FREE_STD_CYC  (FREE_STD_CYC),
        .FREE_FAST_CYC (FREE_FAST_CYC)
    ) u_class (
        .clk       (clk),
        .rst       (rst),
        .fast_mode (fast_mode),
        .scl_f     (lvl_v[LINE_SCL]),
        .sda_f     (lvl_v[LINE_SDA]),
        .ev        (ev_w),
        .busy      (bus_busy)
    );

    i2cmon_drive_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .scl_f (lvl_v[LINE_SCL]),
        .req   (drive_low_req),
        .drive (sda_drive_low)
    );

    assign scl_level      = lvl_v[LINE_SCL];
    assign sda_level      = lvl_v[LINE_SDA];
    assign start_pulse    = ev_w.start;
    assign rstart_pulse   = ev_w.rstart;
    assign stop_pulse     = ev_w.stop;
    assign scl_rise_pulse = ev_w.rise;
    assign scl_fall_pulse = ev_w.fall;

    AST_STOP_NOT_WITH_START: assert property (@(posedge clk) disable iff (rst) !(stop_pulse && (start_pulse || rstart_pulse || scl_rise_pulse))) else $error("stop shares a cycle with another event"); // R7

endmodule

// File: tb/tb_i2c_line_monitor.sv
`timescale 1ns/1ps
module tb_i2c_line_monitor;

    localparam int HOLD = 15;
    localparam int NV   = 22;

    typedef struct packed {
        int scl; int sda; int hold;
        int dst; int drs; int dsp; int dri; int dfa; int busy;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1,1,20, 0,0,0,0,0, 0},  // idle
        '{1,0,20, 1,0,0,0,0, 1},  // R3 start
        '{0,0,20, 0,0,0,0,1, 1},  // R6 fall
        '{0,1,20, 0,0,0,0,0, 1},  // R6 data change, scl low
        '{1,1,20, 0,0,0,1,0, 1},
        '{0,1,20, 0,0,0,0,1, 1},
        '{0,0,20, 0,0,0,0,0, 1},
        '{1,0,20, 0,0,0,1,0, 1},
        '{0,0,20, 0,0,0,0,1, 1},
        '{0,1,20, 0,0,0,0,0, 1},
        '{1,1,20, 0,0,0,1,0, 1},
        '{1,0,20, 0,1,0,0,0, 1},  // R4 repeated start
        '{0,0,20, 0,0,0,0,1, 1},
        '{1,0,20, 0,0,0,1,0, 1},
        '{1,1,20, 0,0,1,0,0, 0},  // R5 stop
        '{1,0,20, 0,0,0,0,0, 0},  // R8 start inside free window
        '{1,1,20, 0,0,1,0,0, 0},
        '{1,1,80, 0,0,0,0,0, 0},
        '{1,0,20, 1,0,0,0,0, 1},  // R8 accepted after window
        '{0,0,20, 0,0,0,0,1, 1},
        '{1,1,20, 0,0,1,0,0, 0},  // R7 scl rise with sda rise
        '{1,1,80, 0,0,0,0,0, 0}
    };

    logic clk = 1'b0;
    logic rst, scl_raw, sda_raw, fast_mode, drive_low_req;
    logic scl_level, sda_level, start_pulse, rstart_pulse, stop_pulse;
    logic scl_rise_pulse, scl_fall_pulse, bus_busy, sda_drive_low;

    int n_chk = 0, n_fail = 0;
    int n_st = 0, n_rs = 0, n_sp = 0, n_ri = 0, n_fa = 0;
    int b_st, b_rs, b_sp, b_ri, b_fa;
    int cyc = 0, fall_cyc = 0, chg_cyc = 0;
    logic drv_prev = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_line_monitor dut (
        .clk(clk), .rst(rst), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .fast_mode(fast_mode), .drive_low_req(drive_low_req),
        .scl_level(scl_level), .sda_level(sda_level),
        .start_pulse(start_pulse), .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse),
        .scl_rise_pulse(scl_rise_pulse), .scl_fall_pulse(scl_fall_pulse),
        .bus_busy(bus_busy), .sda_drive_low(sda_drive_low)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (start_pulse)    n_st <= n_st + 1;
        if (rstart_pulse)   n_rs <= n_rs + 1;
        if (stop_pulse)     n_sp <= n_sp + 1;
        if (scl_rise_pulse) n_ri <= n_ri + 1;
        if (scl_fall_pulse) begin
            n_fa     <= n_fa + 1;
            fall_cyc <= cyc;
        end
        drv_prev <= sda_drive_low;
        if (sda_drive_low != drv_prev) chg_cyc <= cyc;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input string what, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic snap();
        b_st = n_st; b_rs = n_rs; b_sp = n_sp; b_ri = n_ri; b_fa = n_fa;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; scl_raw = 1'b1; sda_raw = 1'b1; fast_mode = 1'b1; drive_low_req = 1'b0;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(10);
        // R1 reset state
        chk("R1", "busy", int'(bus_busy), 0);
        chk("R1", "scl_level", int'(scl_level), 1);
        chk("R1", "sda_level", int'(sda_level), 1);
        chk("R1", "drive", int'(sda_drive_low), 0);
        chk("R1", "pulses", n_st + n_rs + n_sp + n_ri + n_fa, 0);

        // vector table: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            snap();
            scl_raw = VECS[i].scl[0];
            sda_raw = VECS[i].sda[0];
            wait_cyc(VECS[i].hold);
            chk("R3", $sformatf("vec %0d start", i), n_st - b_st, VECS[i].dst);
            chk("R4", $sformatf("vec %0d rstart", i), n_rs - b_rs, VECS[i].drs);
            chk("R5", $sformatf("vec %0d stop", i), n_sp - b_sp, VECS[i].dsp);
            chk("R6/R7", $sformatf("vec %0d rise", i), n_ri - b_ri, VECS[i].dri);
            chk("R6", $sformatf("vec %0d fall", i), n_fa - b_fa, VECS[i].dfa);
            chk("R8", $sformatf("vec %0d busy", i), int'(bus_busy), VECS[i].busy);
        end

        // R2 three-clock sda spike is rejected
        snap();
        sda_raw = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        sda_raw = 1'b1;
        wait_cyc(20);
        chk("R2", "3-clk sda spike start", n_st - b_st, 0);
        chk("R2", "3-clk sda spike busy", int'(bus_busy), 0);

        // R2 four-clock pulse is accepted as start then stop
        snap();
        sda_raw = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        sda_raw = 1'b1;
        wait_cyc(20);
        chk("R2", "4-clk pulse start", n_st - b_st, 1);
        chk("R2", "4-clk pulse stop", n_sp - b_sp, 1);
        wait_cyc(80);

        // R2 scl spike during a transfer
        sda_raw = 1'b0;
        wait_cyc(20);
        chk("R3", "start before scl spike", int'(bus_busy), 1);
        snap();
        scl_raw = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        scl_raw = 1'b1;
        wait_cyc(20);
        chk("R2", "scl spike fall", n_fa - b_fa, 0);
        chk("R2", "scl spike rise", n_ri - b_ri, 0);
        chk("R2", "scl level kept", int'(scl_level), 1);

        // R9 request while scl high is not applied
        drive_low_req = 1'b1;
        wait_cyc(20);
        chk("R9", "drive frozen while scl high", int'(sda_drive_low), 0);
        scl_raw = 1'b0;
        wait_cyc(40);
        chk("R9", "drive applied in low phase", int'(sda_drive_low), 1);
        chk_range("R9", "fall to drive distance", chg_cyc - fall_cyc, HOLD, HOLD + 4);

        // R10 follow request after the hold has elapsed
        drive_low_req = 1'b0;
        wait_cyc(2);
        chk("R10", "release follows", int'(sda_drive_low), 0);
        drive_low_req = 1'b1;
        wait_cyc(2);
        chk("R10", "pull follows", int'(sda_drive_low), 1);
        drive_low_req = 1'b0;
        wait_cyc(4);

        // end transfer in standard mode
        fast_mode = 1'b0;
        scl_raw = 1'b1;
        wait_cyc(20);
        snap();
        sda_raw = 1'b1;
        wait_cyc(20);
        chk("R5", "stop std mode", n_sp - b_sp, 1);

        // R8 long window: 150 clocks is still inside it
        wait_cyc(150);
        snap();
        sda_raw = 1'b0;
        wait_cyc(20);
        chk("R8", "std window start ignored", n_st - b_st, 0);
        chk("R8", "std window busy", int'(bus_busy), 0);
        sda_raw = 1'b1;
        wait_cyc(250);
        snap();
        sda_raw = 1'b0;
        wait_cyc(20);
        chk("R8", "std window elapsed start", n_st - b_st, 1);
        chk("R8", "std window elapsed busy", int'(bus_busy), 1);
        sda_raw = 1'b1;
        wait_cyc(20);
        chk("R5", "final stop busy", int'(bus_busy), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule